// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port with Master and Slave Roles

This block is a byte-wide synchronous serial port. One control input picks whether the port drives the serial clock (master) or follows a clock from another device (slave). Clock idle level, sampling edge and bit order can each be set. In master mode a two-bit code sets the serial clock rate as a fraction of the system clock. Each shift moves one byte out and one byte in at the same time.

The transmit side has no buffer. A written byte goes straight into the shift register, so a write that arrives during a transfer is dropped. The receive side has a second stage. A finished byte is copied into a holding register, which keeps it readable while the next byte shifts in. A completion flag shows that a byte has finished. Pin drive enables follow the role automatically. In master mode the data-in pin is always an input. In slave mode its drive follows a direction input and the select line.

Top module: `spi_port`

## Requirements
- R1: With `enable` high and `master` high, `sck_oe` and `mosi_oe` are 1 and `sck_o` rests at `cpol` whenever `busy` is 0. With `master` low, `sck_oe` and `mosi_oe` are 0.
- R2: A transfer moves 8 bits in each direction. With `cpha`=0, incoming data is taken on the first clock edge of each bit (the edge that leaves the `cpol` level) and outgoing data changes on the second edge. With `cpha`=1, outgoing data changes on the first edge and incoming data is taken on the second.
- R3: With `lsb_first`=1, bit 0 of the byte goes out first and the first received bit lands in bit 0. With `lsb_first`=0, bit 7 goes first and the first received bit lands in bit 7.
- R4: In master mode, `rate_sel` codes 0, 1, 2 and 3 give a serial clock period of 4, 16, 64 and 128 system clocks. This is a half period of 2, 8, 32 and 64 clocks between `sck_o` edges.
- R5: A write (`wr_en`) while `busy` is 1 is ignored, and the byte already shifting goes out unchanged.
- R6: `rx_data` keeps the last completed byte until the next transfer finishes. A new byte overwrites an unread one.
- R7: `done` goes to 1 in the cycle of the 16th serial clock edge. It goes back to 0 only when `rd_en` or `wr_en` pulses after a `stat_rd` pulse that was seen while `done` was 1. A `rd_en` pulse without that status read leaves `done` at 1.
- R8: In master mode `miso_oe` is 0 whatever `miso_dir` is. In slave mode, with `ss_n_i` low, `miso_oe` equals `miso_dir`.
- R9: In slave mode, while `ss_n_i` is high, `miso_oe` is 0, edges on `sck_i` are ignored, and the bit counter returns to zero. A transfer cut short by `ss_n_i` going high sets no flag, and the next full transfer is received correctly.
- R10: In slave mode `rate_sel` has no effect, and transfers complete the same way for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Port enable; low stops any transfer |
| master | input | 1 | 1 = master role, 0 = slave role |
| cpol | input | 1 | Idle level of the serial clock |
| cpha | input | 1 | 0 = take data on the first edge, 1 = on the second |
| lsb_first | input | 1 | 1 = bit 0 first, 0 = bit 7 first |
| rate_sel | input | 2 | Master clock rate code |
| miso_dir | input | 1 | Slave-mode drive request for the data-out pin |
| wr_en | input | 1 | Load `wr_data` into the shift register (and start a master transfer) |
| wr_data | input | DW | Byte to send |
| stat_rd | input | 1 | Status-read strobe that arms the flag clear |
| rd_en | input | 1 | Data-read strobe |
| rx_data | output | DW | Holding register of the last received byte |
| done | output | 1 | Transfer-complete flag |
| busy | output | 1 | Transfer in progress |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Drive enable for the serial clock |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Drive enable for the master data pin |
| mosi_i | input | 1 | Master data in (slave receive) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Drive enable for the slave data pin |
| miso_i | input | 1 | Slave data in (master receive) |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
The case that is hardest to reach from the ports is a slave transfer cut off partway, followed by a clean one. The stimulus lowers the select, gives four clock edges, raises the select, and toggles the serial clock a few more times with the select high. It then runs a full byte. The flag must still be clear after the aborted part, and the full byte must arrive intact, which shows the bit counter was reset. Sampling-edge behaviour is reached by having the bench act as the other device in all four clock modes and in both bit orders. The bench changes its data only on the edges the requirement allows.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          master,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic [1:0]    rate_sel,
  input  logic          miso_dir,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  input  logic          rd_en,
  output logic [DW-1:0] rx_data,
  output logic          done,
  output logic          busy,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  localparam int EW = $clog2(2 * DW);
  localparam logic [EW-1:0] ELAST = EW'(2 * DW - 1);
  localparam int HW = 6;

  logic [DW-1:0] sh, rx_buf;
  logic [EW-1:0] ecnt;
  logic [HW-1:0] div_cnt, half_m1;
  logic          m_act, tgl, bitl, armed, sck_d;
  logic [1:0]    sck_sy, mosi_sy, ss_sy;

  function automatic logic [DW-1:0] shin(input logic [DW-1:0] v, input logic b, input logic lsb);
    return lsb ? {b, v[DW-1:1]} : {v[DW-2:0], b};
  endfunction

  always_comb begin
    case (rate_sel)
      2'd0:    half_m1 = HW'(1);
      2'd1:    half_m1 = HW'(7);
      2'd2:    half_m1 = HW'(31);
      default: half_m1 = HW'(63);
    endcase
  end

  wire ss_hi    = ss_sy[1];
  wire s_edge   = ~master & ~ss_hi & (sck_sy[1] ^ sck_d);
  wire m_edge   = master & m_act & (div_cnt == half_m1);
  wire e        = enable & (m_edge | s_edge);
  wire lead     = ~ecnt[0];
  wire samp_ev  = e & (lead ^ cpha);
  wire shift_ev = e & ~(lead ^ cpha) & ~(cpha & (ecnt == '0));
  wire last     = e & (ecnt == ELAST);
  wire din      = master ? miso_i : mosi_sy[1];
  wire out_bit  = lsb_first ? sh[0] : sh[DW-1];
  wire load     = enable & wr_en & ~busy;

  assign busy    = master ? m_act : (~ss_hi & (ecnt != '0));
  assign sck_o   = master ? (cpol ^ tgl) : cpol;
  assign sck_oe  = enable & master;
  assign mosi_o  = out_bit;
  assign mosi_oe = enable & master;
  assign miso_o  = out_bit;
  assign miso_oe = enable & ~master & ~ss_n_i & miso_dir;
  assign rx_data = rx_buf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      mosi_sy <= '0;
      ss_sy   <= '1;
      sck_d   <= 1'b0;
    end else begin
      sck_sy  <= {sck_sy[0], sck_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      sck_d   <= sck_sy[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      rx_buf  <= '0;
      ecnt    <= '0;
      div_cnt <= '0;
      m_act   <= 1'b0;
      tgl     <= 1'b0;
      bitl    <= 1'b0;
    end else if (!enable) begin
      ecnt    <= '0;
      div_cnt <= '0;
      m_act   <= 1'b0;
      tgl     <= 1'b0;
    end else if (load) begin
      sh <= wr_data;
      if (master) begin
        m_act   <= 1'b1;
        div_cnt <= '0;
        tgl     <= 1'b0;
        ecnt    <= '0;
      end
    end else begin
      if (m_act)    div_cnt <= m_edge ? '0 : div_cnt + 1'b1;
      if (m_edge)   tgl <= ~tgl;
      if (samp_ev)  bitl <= din;
      if (shift_ev) sh <= shin(sh, bitl, lsb_first);
      if (e)        ecnt <= last ? '0 : ecnt + 1'b1;
      if (last) begin
        rx_buf <= shin(sh, cpha ? din : bitl, lsb_first);
        m_act  <= 1'b0;
      end
      if (!master && ss_hi) ecnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= 1'b0;
      armed <= 1'b0;
    end else if (last) begin
      done  <= 1'b1;
      armed <= 1'b0;
    end else if (armed && (rd_en || wr_en)) begin
      done  <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && done) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic master,
  input logic cpol,
  input logic ss_n_i,
  input logic rd_en,
  input logic wr_en,
  input logic done,
  input logic busy,
  input logic sck_o,
  input logic sck_oe,
  input logic mosi_oe,
  input logic miso_oe
);
  p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && master && !busy) |-> (sck_o == cpol));

  p_slave_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> (!sck_oe && !mosi_oe));

  p_miso_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
    master |-> !miso_oe);

  p_miso_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n_i |-> !miso_oe);

  p_done_after_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(rd_en || wr_en));
endmodule

bind spi_port spi_port_chk u_chk (.*);

// File: tb/spi_port_test.sv
module spi_port_test;
  logic       clk = 1'b0;
  logic       rst_n, enable, master, cpol, cpha, lsb_first, miso_dir;
  logic [1:0] rate_sel;
  logic       wr_en, stat_rd, rd_en, sck_i, mosi_i, miso_i, ss_n_i;
  logic [7:0] wr_data, rx_data, mid_rx, got;
  logic       done, busy, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_port uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .master(master), .cpol(cpol),
    .cpha(cpha), .lsb_first(lsb_first), .rate_sel(rate_sel), .miso_dir(miso_dir),
    .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd), .rd_en(rd_en),
    .rx_data(rx_data), .done(done), .busy(busy), .sck_o(sck_o), .sck_oe(sck_oe),
    .sck_i(sck_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0; rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  // bench acts as the slave device while the port is master
  task automatic m_xfer(input logic [7:0] mtx, input logic [7:0] stx, input bit coll,
                        output logic [7:0] g);
    int n, k, b;
    logic prev;
    g = 0; k = 0; n = 0;
    miso_i = lsb_first ? stx[0] : stx[7];
    @(negedge clk); wr_en = 1; wr_data = mtx;
    @(negedge clk); wr_en = 0;
    prev = sck_o;
    while (n < 16) begin
      @(negedge clk);
      wr_en = 0;
      if (sck_o !== prev) begin
        prev = sck_o;
        if ((n % 2 == 0) != cpha) begin
          if (lsb_first) g[k] = mosi_o; else g[7-k] = mosi_o;
          k++;
        end else begin
          b = (n + 1) / 2;
          if (b < 8) miso_i = lsb_first ? stx[b] : stx[7-b];
        end
        if (n == 8) mid_rx = rx_data;
        n++;
      end else if (coll && n == 6) begin
        wr_en = 1; wr_data = ~mtx; coll = 0;
      end
    end
    @(negedge clk);
  endtask

  // bench acts as the master device while the port is slave
  task automatic s_xfer(input logic [7:0] btx, input logic [7:0] dtx, input int stop_at,
                        output logic [7:0] g);
    int k, b;
    g = 0; k = 0;
    @(negedge clk); wr_en = 1; wr_data = dtx;
    @(negedge clk); wr_en = 0;
    mosi_i = lsb_first ? btx[0] : btx[7];
    ss_n_i = 0;
    repeat (8) @(negedge clk);
    for (int n = 0; n < stop_at; n++) begin
      if ((n % 2 == 0) != cpha) begin
        if (lsb_first) g[k] = miso_o; else g[7-k] = miso_o;
        k++;
      end
      sck_i = ~sck_i;
      if ((n % 2 == 0) == cpha) begin
        b = (n + 1) / 2;
        if (b < 8) mosi_i = lsb_first ? btx[b] : btx[7-b];
      end
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    ss_n_i = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R7 done after reset", done, 0);
    check("R1 busy after reset", busy, 0);
    check("R6 rx_data after reset", rx_data, 0);
    check("R1 sck_oe while disabled", sck_oe, 0);
    check("R8 miso_oe after reset", miso_oe, 0);
  endtask

  task automatic t_master_modes();
    logic [7:0] m, s;
    master = 1; rate_sel = 0;
    for (int md = 0; md < 8; md++) begin
      cpol = md[0]; cpha = md[1]; lsb_first = md[2];
      m = 8'h1B + 8'(md * 37); s = 8'hE4 ^ 8'(md * 19);
      @(negedge clk);
      check("R1 idle sck level", sck_o, cpol);
      check("R1 master drives sck/mosi", {sck_oe, mosi_oe}, 2'b11);
      m_xfer(m, s, 0, got);
      check("R2/R3 mosi byte and order", got, m);
      check("R2/R3 received byte", rx_data, s);
      check("R7 flag after 8 bits", done, 1);
      check("R1 sck back at idle", sck_o, cpol);
      clear_flag();
    end
    lsb_first = 1; cpol = 0; cpha = 0;
    m_xfer(8'h01, 8'h80, 0, got);
    check("R3 lsb-first word", got, 8'h01);
    check("R3 lsb-first receive", rx_data, 8'h80);
    clear_flag();
  endtask

  task automatic t_rate();
    int cyc;
    logic p;
    master = 1; cpol = 0; cpha = 0; lsb_first = 0;
    for (int r = 0; r < 4; r++) begin
      rate_sel = 2'(r);
      @(negedge clk); wr_en = 1; wr_data = 8'h55;
      @(negedge clk); wr_en = 0;
      while (sck_o === cpol) @(negedge clk);
      p = sck_o; cyc = 0;
      while (sck_o === p) begin @(negedge clk); cyc++; end
      check("R4 half period for rate code", cyc, (r == 0) ? 2 : (r == 1) ? 8 : (r == 2) ? 32 : 64);
      while (busy) @(negedge clk);
      clear_flag();
    end
    rate_sel = 0;
  endtask

  task automatic t_collision();
    master = 1; cpol = 1; cpha = 1; lsb_first = 0;
    m_xfer(8'hA5, 8'h3C, 1, got);
    check("R5 write during transfer ignored", got, 8'hA5);
    check("R5 receive unaffected", rx_data, 8'h3C);
    clear_flag();
  endtask

  task automatic t_flag_overrun();
    master = 1; cpol = 0; cpha = 0; lsb_first = 0;
    m_xfer(8'h11, 8'h5A, 0, got);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    @(negedge clk);
    check("R7 read without status keeps flag", done, 1);
    m_xfer(8'h22, 8'hC3, 0, got);
    check("R6 holding byte kept mid-transfer", mid_rx, 8'h5A);
    check("R6 unread byte overwritten", rx_data, 8'hC3);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    @(negedge clk);
    check("R7 status alone keeps flag", done, 1);
    rd_en = 1;
    @(negedge clk); rd_en = 0;
    @(negedge clk);
    check("R7 status then read clears flag", done, 0);
  endtask

  task automatic t_miso_dir();
    master = 1; miso_dir = 1; ss_n_i = 0;
    @(negedge clk);
    check("R8 master forces miso input", miso_oe, 0);
    master = 0;
    @(negedge clk);
    check("R8 slave follows direction=1", miso_oe, 1);
    check("R1 slave releases sck/mosi", {sck_oe, mosi_oe}, 2'b00);
    miso_dir = 0;
    @(negedge clk);
    check("R8 slave follows direction=0", miso_oe, 0);
    miso_dir = 1; ss_n_i = 1;
    @(negedge clk);
    check("R9 deselected slave tri-states miso", miso_oe, 0);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_slave();
    logic [7:0] b, d;
    master = 0; miso_dir = 1; ss_n_i = 1;
    for (int md = 0; md < 8; md++) begin
      cpol = md[0]; cpha = md[1]; lsb_first = md[2];
      rate_sel = 2'(md % 4);
      sck_i = cpol;
      repeat (6) @(negedge clk);
      b = 8'h96 ^ 8'(md * 23); d = 8'h4D + 8'(md * 41);
      s_xfer(b, d, 16, got);
      check("R2/R3 slave receive", rx_data, b);
      check("R2/R3 slave send", got, d);
      check("R10 slave done regardless of rate", done, 1);
      clear_flag();
    end
  endtask

  task automatic t_slave_abort();
    master = 0; cpol = 0; cpha = 0; lsb_first = 0; rate_sel = 3;
    sck_i = 0;
    repeat (6) @(negedge clk);
    s_xfer(8'hFF, 8'h00, 4, got);
    check("R9 aborted transfer sets no flag", done, 0);
    for (int i = 0; i < 6; i++) begin
      sck_i = ~sck_i;
      repeat (4) @(negedge clk);
    end
    check("R9 sck ignored while deselected", done, 0);
    s_xfer(8'h6E, 8'hB1, 16, got);
    check("R9 counter reset, next byte received", rx_data, 8'h6E);
    check("R9 counter reset, next byte sent", got, 8'hB1);
    clear_flag();
  endtask

  initial begin
    rst_n = 0; enable = 0; master = 1; cpol = 0; cpha = 0; lsb_first = 0;
    rate_sel = 0; miso_dir = 0; wr_en = 0; wr_data = 0; stat_rd = 0; rd_en = 0;
    sck_i = 0; mosi_i = 0; miso_i = 0; ss_n_i = 1; mid_rx = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    enable = 1;
    t_master_modes();
    t_rate();
    t_collision();
    t_flag_overrun();
    t_miso_dir();
    t_slave();
    t_slave_abort();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
  end
endmodule